// File: doc/BRIEF.md
# Biphase-Mark Digital Audio Transmitter with Programmable Channel Status

This block turns a stream of stereo samples into a single-wire biphase-mark coded serial stream of the consumer digital audio kind. Each stereo sample becomes one frame of two subframes, left then right. Every subframe carries a sync preamble, four auxiliary bits, a 20-bit audio field and four flag bits: validity, user data, channel status and parity. An upstream source hands over one stereo sample per frame through a ready/valid handshake. The sample is either linear PCM of up to 20 bits or a 16-bit coded word passed through unchanged.

Channel status is organised in blocks of 192 frames. The first 40 status bits of a block come from five writable status bytes, and every later bit is zero. User data is read from a 129-byte message store at two bits per frame, and wraps around at the end of the store. A simple write port loads the status bytes and the message store. After reset both hold zeros, so a transmitter that has never been configured sends all-zero user data and status.

Top module: `spdif_tx`

## Requirements
- R1: While reset is asserted and in the first clock after it, `tx_out` is 0 and `smp_ready` is 1. Reset clears all five status bytes and all 129 message bytes to zero.
- R2: Each subframe is 32 slots. Slots 0-3 are the preamble and slots 4-7 are auxiliary bits, always 0. Slots 8-27 carry the 20-bit audio field LSB first. Slot 28 is validity, slot 29 user data, slot 30 channel status and slot 31 parity.
- R3: The left subframe of frame 0 of a block uses preamble B, other left subframes use M, and every right subframe uses W. Each preamble is 8 half-cells. When the level before it is low they read B=11101000, M=11100010 and W=11100100, first half-cell leftmost. They are inverted when the level before is high.
- R4: Slots 4-31 are biphase-mark coded. The level toggles at the start of every slot and toggles again at mid-slot when the bit is 1. Every half-cell lasts HALF_DIV clocks, and a frame lasts 128 half-cells.
- R5: The parity slot makes the number of ones in slots 4-31 even, so the line is low before every preamble.
- R6: When `smp_coded` is 0 the 20-bit inputs go into the audio field unchanged. When it is 1, input bits 15:0 go into audio field bits 19:4 and field bits 3:0 are 0.
- R7: A one-entry holding register accepts a sample when `smp_valid` and `smp_ready` are both 1, and `smp_ready` is 0 while it is full. The sample is taken at the first clock of each frame. If none is held, both subframes send an all-zero audio field with validity 1. A sample that is present is sent with validity 0.
- R8: A write with `wr_status`=1 and address 0-4 sets status byte n. Frame f of a block (0-191) carries bit f%8 of status byte f/8 in both subframes for f<40, and 0 for f>=40.
- R9: A write with `wr_status`=0 and address 0-128 sets message byte a. Stream bit j is bit j%8 of byte j/8. Frame k after reset sends bit 2k (left) and 2k+1 (right), modulo 1032.
- R10: Writes with `wr_status`=1 and address 5-255, and writes with `wr_status`=0 and address 129-255, change nothing.
- R11: The validity, user and status values of a subframe are captured at its first clock. A write or handshake later in that subframe does not alter its bits or its parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| smp_valid | input | 1 | a stereo sample is offered |
| smp_ready | output | 1 | holding register is empty |
| smp_left | input | 20 | left sample or coded word |
| smp_right | input | 20 | right sample or coded word |
| smp_coded | input | 1 | 1: 16-bit coded pass-through words |
| wr_en | input | 1 | write strobe |
| wr_status | input | 1 | 1: status bytes, 0: message store |
| wr_addr | input | 8 | byte index |
| wr_data | input | 8 | byte value |
| tx_out | output | 1 | biphase-mark coded serial line |

## Verification
The line level is compared every clock against a behavioural model, so a fault shows up within one half-cell. A slipped half-cell or frame counter corrupts the next preamble within one subframe. A block counter that drifts shows up as a misplaced B preamble or a wrong status bit in the next frame. A user pointer that moves at the wrong rate or wraps at the wrong length gives a wrong user bit in the first frame after the error. The long stream crosses the 516-frame wrap of the message store and several 192-frame blocks to expose exactly that. A wrong capture moment for a sample shows in the next frame's validity bit, and one for a write shows in the next subframe's parity bit.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int AUD_W      = 20;
    localparam int CODED_W    = 16;
    localparam int AUX_W      = 4;
    localparam int HC_W       = 7;      // 128 half-cells per frame
    localparam int PAY_W      = AUX_W + AUD_W + 3;

    typedef enum logic [1:0] {
        SYNC_BLOCK = 2'd0,
        SYNC_LEFT  = 2'd1,
        SYNC_RIGHT = 2'd2
    } sync_e;

    typedef struct packed {
        logic [AUD_W-1:0] left;
        logic [AUD_W-1:0] right;
        logic             invalid;
    } stereo_t;

    // MSB to LSB: status, user, validity, audio, aux (slot 30 down to 4)
    typedef struct packed {
        logic             cs;
        logic             ud;
        logic             vf;
        logic [AUD_W-1:0] aud;
        logic [AUX_W-1:0] aux;
    } payload_t;

    // bit 7 is the first half-cell, pattern for a low prior level
    function automatic logic [7:0] sync_pattern(sync_e kind);
        case (kind)
            SYNC_BLOCK: return 8'b1110_1000;
            SYNC_LEFT:  return 8'b1110_0010;
            default:    return 8'b1110_0100;
        endcase
    endfunction

    function automatic logic [AUD_W-1:0] place_word(logic [AUD_W-1:0] w, logic coded);
        if (coded)
            return {w[CODED_W-1:0], {(AUD_W-CODED_W){1'b0}}};
        return w;
    endfunction

endpackage

// File: rtl/spdif_tx_timebase.sv
module spdif_tx_timebase
    import spdif_tx_pkg::*;
#(
    parameter int HALF_DIV     = 2,
    parameter int BLOCK_FRAMES = 192,
    parameter int FR_W         = $clog2(BLOCK_FRAMES)
) (
    input  logic            clk,
    input  logic            rst,
    output logic            cell_go,
    output logic [HC_W-1:0] hc,
    output logic [FR_W-1:0] fr
);

    logic last_clk;

    generate
        if (HALF_DIV > 1) begin : g_div
            localparam int DW = $clog2(HALF_DIV);
            logic [DW-1:0] div_q;
            always_ff @(posedge clk) begin
                if (rst)
                    div_q <= '0;
                else if (div_q == DW'(HALF_DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end
            assign cell_go  = (div_q == '0);
            assign last_clk = (div_q == DW'(HALF_DIV - 1));
        end else begin : g_nodiv
            assign cell_go  = 1'b1;
            assign last_clk = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hc <= '0;
            fr <= '0;
        end else if (last_clk) begin
            hc <= hc + 1'b1;
            if (hc == '1)
                fr <= (fr == FR_W'(BLOCK_FRAMES - 1)) ? '0 : fr + 1'b1;
        end
    end

endmodule

// File: rtl/spdif_tx_regs.sv
module spdif_tx_regs #(
    parameter int UBUF_BYTES = 129,
    parameter int CS_BYTES   = 5,
    parameter int ADDR_W     = 8,
    parameter int FR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_status,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              right_start,
    input  logic [FR_W-1:0]   fr,
    output logic              c_bit,
    output logic              u_left,
    output logic              u_right
);

    localparam int UB_BITS = UBUF_BYTES * 8;
    localparam int PAIRS   = UBUF_BYTES * 4;
    localparam int PW      = $clog2(PAIRS);
    localparam int CS_BITS = CS_BYTES * 8;
    localparam int CW      = $clog2(CS_BITS);

    logic [UB_BITS-1:0] ubits;
    logic [CS_BITS-1:0] csbits;
    logic [PW-1:0]      pair;

    always_ff @(posedge clk) begin
        if (rst) begin
            ubits  <= '0;
            csbits <= '0;
            pair   <= '0;
        end else begin
            if (wr_en && !wr_status && (int'(wr_addr) < UBUF_BYTES))
                ubits[{wr_addr, 3'b000} +: 8] <= wr_data;
            if (wr_en && wr_status && (int'(wr_addr) < CS_BYTES))
                csbits[{wr_addr, 3'b000} +: 8] <= wr_data;
            if (right_start)
                pair <= (pair == PW'(PAIRS - 1)) ? '0 : pair + 1'b1;
        end
    end

    assign u_left  = ubits[{pair, 1'b0}];
    assign u_right = ubits[{pair, 1'b1}];
    assign c_bit   = (int'(fr) < CS_BITS) ? csbits[fr[CW-1:0]] : 1'b0;

endmodule

// File: rtl/spdif_tx_encoder.sv
module spdif_tx_encoder
    import spdif_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cell_go,
    input  logic [HC_W-1:0]  hc,
    input  logic             block_first,
    input  logic             frame_start,
    input  logic             right_start,
    input  logic [AUD_W-1:0] left_word,
    input  logic             left_inv,
    input  logic [AUD_W-1:0] right_word,
    input  logic             right_inv,
    input  logic             c_bit,
    input  logic             u_left,
    input  logic             u_right,
    output logic             tx_out
);

    payload_t         pay_r;
    logic [PAY_W-1:0] pay_bits;
    logic             base_r;
    logic [5:0]       s;
    logic [4:0]       slot;
    logic [4:0]       idx;
    logic [7:0]       pat;
    sync_e            kind;
    logic             prev_lvl;
    logic             bitv;
    logic             lvl;

    assign pay_bits = pay_r;

    always_comb begin
        s        = hc[5:0];
        slot     = s[5:1];
        idx      = slot - 5'd4;
        kind     = hc[6] ? SYNC_RIGHT : (block_first ? SYNC_BLOCK : SYNC_LEFT);
        pat      = sync_pattern(kind);
        prev_lvl = (s == 6'd0) ? tx_out : base_r;
        bitv     = 1'b0;
        if (slot < 5'd4) begin
            lvl = pat[3'd7 - s[2:0]] ^ prev_lvl;
        end else begin
            bitv = (slot == 5'd31) ? ^pay_bits : pay_bits[idx];
            if (!s[0])
                lvl = ~tx_out;
            else
                lvl = bitv ? ~tx_out : tx_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pay_r  <= '0;
            base_r <= 1'b0;
            tx_out <= 1'b0;
        end else begin
            if (frame_start)
                pay_r <= '{cs: c_bit, ud: u_left, vf: left_inv, aud: left_word, aux: '0};
            else if (right_start)
                pay_r <= '{cs: c_bit, ud: u_right, vf: right_inv, aud: right_word, aux: '0};
            if (cell_go) begin
                if (s == 6'd0)
                    base_r <= tx_out;
                tx_out <= lvl;
            end
        end
    end

endmodule

// File: rtl/spdif_tx.sv
module spdif_tx
    import spdif_tx_pkg::*;
#(
    parameter int HALF_DIV     = 2,
    parameter int BLOCK_FRAMES = 192,
    parameter int UBUF_BYTES   = 129,
    parameter int CS_BYTES     = 5,
    parameter int ADDR_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    output logic              smp_ready,
    input  logic [19:0]       smp_left,
    input  logic [19:0]       smp_right,
    input  logic              smp_coded,
    input  logic              wr_en,
    input  logic              wr_status,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              tx_out
);

    localparam int FR_W = $clog2(BLOCK_FRAMES);

    logic            cell_go;
    logic [HC_W-1:0] hc;
    logic [FR_W-1:0] fr;
    logic            frame_start;
    logic            right_start;
    logic            c_bit;
    logic            u_left;
    logic            u_right;

    stereo_t hold_r;
    logic    hold_full;
    stereo_t frame_r;
    stereo_t cur;

    spdif_tx_timebase #(
        .HALF_DIV     (HALF_DIV),
        .BLOCK_FRAMES (BLOCK_FRAMES),
        .FR_W         (FR_W)
    ) i_timebase (
        .clk     (clk),
        .rst     (rst),
        .cell_go (cell_go),
        .hc      (hc),
        .fr      (fr)
    );

    assign frame_start = cell_go && (hc == HC_W'(0));
    assign right_start = cell_go && (hc == HC_W'(64));

    spdif_tx_regs #(
        .UBUF_BYTES (UBUF_BYTES),
        .CS_BYTES   (CS_BYTES),
        .ADDR_W     (ADDR_W),
        .FR_W       (FR_W)
    ) i_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_status   (wr_status),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .right_start (right_start),
        .fr          (fr),
        .c_bit       (c_bit),
        .u_left      (u_left),
        .u_right     (u_right)
    );

    assign smp_ready = !hold_full;
    assign cur = hold_full ? hold_r : '{left: '0, right: '0, invalid: 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_r    <= '0;
            hold_full <= 1'b0;
            frame_r   <= '{left: '0, right: '0, invalid: 1'b1};
        end else begin
            if (frame_start) begin
                frame_r   <= cur;
                hold_full <= 1'b0;
            end
            if (smp_valid && !hold_full) begin
                hold_r    <= '{left:    place_word(smp_left, smp_coded),
                               right:   place_word(smp_right, smp_coded),
                               invalid: 1'b0};
                hold_full <= 1'b1;
            end
        end
    end

    spdif_tx_encoder i_encoder (
        .clk         (clk),
        .rst         (rst),
        .cell_go     (cell_go),
        .hc          (hc),
        .block_first (fr == '0),
        .frame_start (frame_start),
        .right_start (right_start),
        .left_word   (cur.left),
        .left_inv    (cur.invalid),
        .right_word  (frame_r.right),
        .right_inv   (frame_r.invalid),
        .c_bit       (c_bit),
        .u_left      (u_left),
        .u_right     (u_right),
        .tx_out      (tx_out)
    );

endmodule

// File: rtl/spdif_tx_checker.sv
module spdif_tx_checker #(
    parameter int FR_W    = 8,
    parameter int CS_BITS = 40
) (
    input logic            clk,
    input logic            rst,
    input logic            tx_out,
    input logic            smp_valid,
    input logic            smp_ready,
    input logic            cell_go,
    input logic [5:0]      hc_sub,
    input logic [FR_W-1:0] fr,
    input logic            c_bit
);

    a_r7_full_after_take: assert property (@(posedge clk) disable iff (rst)
        smp_valid && smp_ready |=> !smp_ready);

    a_r4_slot_edge: assert property (@(posedge clk) disable iff (rst)
        cell_go && !hc_sub[0] && (hc_sub[5:3] != 3'd0) |=> tx_out != $past(tx_out));

    a_r4_hold_cell: assert property (@(posedge clk) disable iff (rst)
        !cell_go |=> $stable(tx_out));

    a_r5_low_before_sync: assert property (@(posedge clk) disable iff (rst)
        cell_go && (hc_sub == 6'd0) |-> !tx_out);

    a_r3_sync_leads_high: assert property (@(posedge clk) disable iff (rst)
        cell_go && (hc_sub == 6'd0) |=> tx_out);

    a_r8_status_tail_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(fr) >= CS_BITS) |-> !c_bit);

endmodule

bind spdif_tx spdif_tx_checker #(
    .FR_W    (FR_W),
    .CS_BITS (CS_BYTES * 8)
) i_checker (
    .clk       (clk),
    .rst       (rst),
    .tx_out    (tx_out),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .cell_go   (cell_go),
    .hc_sub    (hc[5:0]),
    .fr        (fr),
    .c_bit     (c_bit)
);

// File: tb/test_spdif_tx.sv
module test_spdif_tx;

    localparam int HD  = 1;
    localparam int CPF = 128 * HD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [19:0] smp_left = '0;
    logic [19:0] smp_right = '0;
    logic        smp_coded = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_status = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        smp_ready;
    logic        tx_out;

    always #4 clk = ~clk;

    spdif_tx #(.HALF_DIV(HD)) i_spdif_tx (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_coded (smp_coded),
        .wr_en     (wr_en),
        .wr_status (wr_status),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .tx_out    (tx_out)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string phase = "R1 reset";
    bit    done = 1'b0;

    // behavioural reference model
    logic        mlv [128];
    logic [7:0]  m_cs [5];
    logic [7:0]  m_ub [129];
    logic        m_full;
    logic [19:0] m_hl, m_hr, m_fl, m_fr;
    logic        m_finv;
    int          m_pair, m_frame, ec, shown_h, h;
    logic        exp_tx, exp_rdy;
    bit          rdy_pre, at_start;

    function automatic logic [19:0] place(logic [19:0] w, logic c);
        return c ? {w[15:0], 4'h0} : w;   // R6
    endfunction

    function automatic logic ubit(int j);
        return m_ub[j / 8][j % 8];        // R9
    endfunction

    function automatic logic csbit(int f);
        if (f < 40) return m_cs[f / 8][f % 8];   // R8
        return 1'b0;
    endfunction

    task automatic fill(int at, int kind, logic [19:0] aud, logic v, logic u, logic c, logic prev);
        logic       b [32];
        logic [7:0] pat;
        logic       lv;
        logic       par;
        pat = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
        for (int k = 0; k < 8; k++) mlv[at + k] = pat[7 - k] ^ prev;
        for (int k = 0; k < 32; k++) b[k] = 1'b0;
        for (int k = 0; k < 20; k++) b[8 + k] = aud[k];
        b[28] = v; b[29] = u; b[30] = c;
        par = 1'b0;
        for (int k = 4; k < 31; k++) par = par ^ b[k];
        b[31] = par;
        lv = mlv[at + 7];
        for (int k = 4; k < 32; k++) begin
            lv = ~lv;
            mlv[at + 2 * k] = lv;
            if (b[k]) lv = ~lv;
            mlv[at + 2 * k + 1] = lv;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_full = 1'b0; m_pair = 0; m_frame = 0; ec = 0; shown_h = 0;
            for (int k = 0; k < 5; k++) m_cs[k] = 8'h00;
            for (int k = 0; k < 129; k++) m_ub[k] = 8'h00;
            for (int k = 0; k < 128; k++) mlv[k] = 1'b0;
            exp_tx = 1'b0; exp_rdy = 1'b1;
        end else begin
            h = (ec / HD) % 128;
            at_start = (ec % HD) == 0;
            rdy_pre = !m_full;
            if (at_start && h == 0) begin
                if (m_full) begin m_fl = m_hl; m_fr = m_hr; m_finv = 1'b0; end
                else begin m_fl = '0; m_fr = '0; m_finv = 1'b1; end
                m_full = 1'b0;
                fill(0, (m_frame == 0) ? 0 : 1, m_fl, m_finv, ubit(2 * m_pair), csbit(m_frame), mlv[127]);
            end
            if (at_start && h == 64) begin
                fill(64, 2, m_fr, m_finv, ubit(2 * m_pair + 1), csbit(m_frame), mlv[63]);
                m_pair = (m_pair + 1) % 516;
            end
            exp_tx = mlv[h];
            shown_h = h;
            if ((ec % HD) == HD - 1 && h == 127) m_frame = (m_frame + 1) % 192;
            if (wr_en) begin   // R10: out-of-range writes dropped
                if (wr_status && wr_addr < 5) m_cs[wr_addr] = wr_data;
                if (!wr_status && wr_addr < 129) m_ub[wr_addr] = wr_data;
            end
            if (smp_valid && rdy_pre) begin
                m_hl = place(smp_left, smp_coded);
                m_hr = place(smp_right, smp_coded);
                m_full = 1'b1;
            end
            exp_rdy = !m_full;
            ec++;
        end
    end

    function automatic string slot_tag(int hh);
        int sl;
        sl = (hh % 64) / 2;
        if (sl < 4)   return "R3";
        if (sl < 8)   return "R2 R4 aux";
        if (sl < 28)  return "R2 R4 R6 audio";
        if (sl == 28) return "R4 R7 validity";
        if (sl == 29) return "R4 R9 R11 user";
        if (sl == 30) return "R4 R8 R11 status";
        return "R4 R5 parity";
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            vectors++;
            if (rst) begin
                if (tx_out !== 1'b0 || smp_ready !== 1'b1) begin
                    miscompares++;
                    $display("FAIL R1 reset: tx_out=%b smp_ready=%b expected 0 1", tx_out, smp_ready);
                end
            end else begin
                if (tx_out !== exp_tx) begin
                    miscompares++;
                    $display("FAIL %s [%s] half-cell %0d: tx_out=%b expected %b",
                             slot_tag(shown_h), phase, shown_h, tx_out, exp_tx);
                end
                if (smp_ready !== exp_rdy) begin
                    miscompares++;
                    $display("FAIL R7 [%s] smp_ready=%b expected %b", phase, smp_ready, exp_rdy);
                end
            end
        end
    end

    task automatic send(logic [19:0] l, logic [19:0] r, logic c);
        @(negedge clk);
        smp_valid = 1'b1; smp_left = l; smp_right = r; smp_coded = c;
        while (!smp_ready) @(negedge clk);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wr(logic st, logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_status = st; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [31:0] seed;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        phase = "R1 R7 underrun";
        repeat (2 * CPF) @(negedge clk);
        phase = "R2 R6 pcm";
        send(20'hFFFFF, 20'h00000, 1'b0);
        send(20'hAAAAA, 20'h55555, 1'b0);
        send(20'h80001, 20'h7FFFE, 1'b0);
        send(20'h12345, 20'hFEDCB, 1'b0);
        phase = "R6 coded";
        send(20'h0BEEF, 20'hA5A5A, 1'b1);
        send(20'hFFFFF, 20'h0000F, 1'b1);
        phase = "R8 R10 status";
        wr(1'b1, 8'd0, 8'hA5); wr(1'b1, 8'd1, 8'h3C); wr(1'b1, 8'd2, 8'hF0);
        wr(1'b1, 8'd3, 8'h0F); wr(1'b1, 8'd4, 8'h81);
        wr(1'b1, 8'd5, 8'hFF); wr(1'b1, 8'd7, 8'hFF); wr(1'b1, 8'd200, 8'hFF);
        phase = "R9 R10 user";
        for (int i = 0; i < 129; i++) wr(1'b0, 8'(i), 8'((i * 37 + 11) & 8'hFF));
        wr(1'b0, 8'd129, 8'hFF); wr(1'b0, 8'd200, 8'hFF); wr(1'b0, 8'd255, 8'hFF);
        phase = "R7 R8 R9 R11 stream";
        seed = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            if (i % 97 == 50) repeat (3 * CPF) @(negedge clk);
            if (i == 300) begin
                wr(1'b1, 8'd0, 8'h5A);
                wr(1'b0, 8'd7, 8'hC3);
            end
            seed = seed * 32'd1664525 + 32'd1013904223;
            send(seed[31:12], seed[19:0], (i / 8) % 2 == 1);
        end
        repeat (2 * CPF) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule